// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches the live BCD calendar counters of a real-time clock and raises an alarm when they reach a programmed moment. It holds six alarm registers, one for each time field: second, minute, hour, weekday, day of month and month. Each register carries a compare-enable in its top bit. A field whose enable is clear is a wildcard, so software can match any subset of fields. For example, it can match "every hour at minute 30" or "on the 12th month only".

The comparison is evaluated once per seconds tick. It counts as a hit only when at least one field is enabled and every enabled field equals its counter. On the first tick of a hit, a sticky alarm flag is set. The host clears the flag by writing a zero to it. The interrupt output is the flag gated by an interrupt-enable bit. The time counters themselves and year matching are supplied outside this block.

Top module: `rtca_alarm_top`

## Requirements
- R1: After reset every alarm register reads as disabled (0x00), and the alarm flag, the interrupt enable and the interrupt output are all 0.
- R2: A host write at index 8 to 13 loads the alarm register for, in that order, second, minute, hour, weekday, day and month. Bit 7 of the written byte is the field's compare enable, and bits 6:0 are the BCD target. The month target uses the same 1 to 12 BCD encoding as the month counter.
- R3: A field whose bit 7 is 0 is ignored in the comparison, whatever its target bits and its counter hold.
- R4: A hit requires every enabled field to equal its counter. A single enabled field that differs prevents the flag from setting.
- R5: When no field is enabled, the alarm flag never sets.
- R6: The comparison is taken only on a cycle where `sec_tick` is 1. A matching counter state without a tick leaves the flag unchanged.
- R7: The flag sets only on a tick where the hit is true and was false on the previous tick. A hit held across consecutive ticks does not set the flag again after it was cleared.
- R8: A host write at index 14 is the control register. Writing bit 0 as 0 clears the alarm flag, and writing it as 1 leaves the flag as it was. Bit 3 is stored as the interrupt enable.
- R9: `alarm_irq` equals the alarm flag ANDed with the interrupt enable.
- R10: When a flag set and a host clear land in the same cycle, the flag ends up set.
- R11: A host write at any index outside 8 to 14 changes no alarm register and no control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_idx | input | 4 | Host register index |
| host_wdata | input | 8 | Host write data |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| cnt_sec | input | 8 | BCD seconds counter |
| cnt_min | input | 8 | BCD minutes counter |
| cnt_hour | input | 8 | BCD hours counter |
| cnt_wday | input | 8 | BCD weekday counter |
| cnt_day | input | 8 | BCD day-of-month counter |
| cnt_mon | input | 8 | BCD month counter (1 to 12) |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The bench targets the wildcard logic in several ways. It checks a disabled field holding a mismatching value, which a design comparing all six bytes would miss. It checks an alarm with every field disabled, which a design that reduces over an empty set to "true" would fire on every tick. It checks a target written to the minute slot while the matching value sits in the seconds counter, which catches a swapped field order. For the edge detection, it holds a match across several ticks after a clear; a level-sensitive design would re-set the flag. It also lands a host clear in the same cycle as a new hit; a design that gives the clear priority loses the alarm. Finally, it writes 1 to the flag bit and writes to neighbouring indices, either of which a loose decoder would let alter the flag, the enable or the alarm registers.

// File: rtl/rtca_pkg.sv
package rtca_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_FIELDS = 6;
  localparam int EN_BIT     = 7;
  localparam int FLAG_BIT   = 0;
  localparam int IE_BIT     = 3;

  typedef logic [BYTE_W-1:0] bcd_t;

  // Field order equals host index order starting at the alarm base
  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_WDAY = 3'd3,
    FLD_DAY  = 3'd4,
    FLD_MON  = 3'd5
  } field_e;

  // One field agrees when its enable is clear or its target equals the counter
  function automatic logic field_agrees(input bcd_t alarm_b, input bcd_t cnt_b);
    logic [BYTE_W-1:0] target;
    target = {1'b0, alarm_b[EN_BIT-1:0]};
    return !alarm_b[EN_BIT] || (target == cnt_b);
  endfunction
endpackage

// File: rtl/rtca_alarm_regs.sv
module rtca_alarm_regs
  import rtca_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int BASE_IDX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] idx,
  input  bcd_t              wdata,
  output bcd_t              alarm_q [NUM_FIELDS],
  output logic              any_en
);
  logic [NUM_FIELDS-1:0] en_vec;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    localparam logic [ADDR_W-1:0] MY_IDX = ADDR_W'(BASE_IDX + g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        alarm_q[g] <= '0;
      end else if (we && (idx == MY_IDX)) begin
        alarm_q[g] <= wdata;
      end
    end
    assign en_vec[g] = alarm_q[g][EN_BIT];
  end

  assign any_en = |en_vec;
endmodule

// File: rtl/rtca_match.sv
module rtca_match
  import rtca_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  bcd_t alarm_q [NUM_FIELDS],
  input  bcd_t cnt     [NUM_FIELDS],
  input  logic any_en,
  output logic hit_now,
  output logic fire
);
  logic [NUM_FIELDS-1:0] agree;
  logic                  prev_hit;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    assign agree[g] = field_agrees(alarm_q[g], cnt[g]);
  end

  assign hit_now = any_en && (&agree);
  assign fire    = tick && hit_now && !prev_hit;

  // Hit state remembered from the last tick only
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_hit <= 1'b0;
    end else if (tick) begin
      prev_hit <= hit_now;
    end
  end
endmodule

// File: rtl/rtca_flag_ctl.sv
module rtca_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic ctrl_we,
  input  logic wr_flag_bit,
  input  logic wr_ie_bit,
  output logic clr_req,
  output logic flag_q,
  output logic ie_q,
  output logic irq
);
  assign clr_req = ctrl_we && !wr_flag_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (fire) begin
        flag_q <= 1'b1;
      end else if (clr_req) begin
        flag_q <= 1'b0;
      end
      if (ctrl_we) begin
        ie_q <= wr_ie_bit;
      end
    end
  end

  assign irq = flag_q && ie_q;
endmodule

// File: rtl/rtca_alarm_top.sv
module rtca_alarm_top
  import rtca_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int BASE_IDX = 8,
  parameter int CTRL_IDX = BASE_IDX + NUM_FIELDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_idx,
  input  logic [7:0]        host_wdata,
  input  logic              sec_tick,
  input  logic [7:0]        cnt_sec,
  input  logic [7:0]        cnt_min,
  input  logic [7:0]        cnt_hour,
  input  logic [7:0]        cnt_wday,
  input  logic [7:0]        cnt_day,
  input  logic [7:0]        cnt_mon,
  output logic              alarm_flag,
  output logic              alarm_irq
);
  localparam logic [ADDR_W-1:0] CTRL_SEL = ADDR_W'(CTRL_IDX);

  bcd_t alarm_q [NUM_FIELDS];
  bcd_t cnt_arr [NUM_FIELDS];
  logic any_en;
  logic hit_now;
  logic fire;
  logic ctrl_we;
  logic clr_req;
  logic ie_q;

  assign cnt_arr[FLD_SEC]  = cnt_sec;
  assign cnt_arr[FLD_MIN]  = cnt_min;
  assign cnt_arr[FLD_HOUR] = cnt_hour;
  assign cnt_arr[FLD_WDAY] = cnt_wday;
  assign cnt_arr[FLD_DAY]  = cnt_day;
  assign cnt_arr[FLD_MON]  = cnt_mon;

  assign ctrl_we = host_we && (host_idx == CTRL_SEL);

  rtca_alarm_regs #(.ADDR_W(ADDR_W), .BASE_IDX(BASE_IDX)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (host_we),
    .idx     (host_idx),
    .wdata   (host_wdata),
    .alarm_q (alarm_q),
    .any_en  (any_en)
  );

  rtca_match u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (sec_tick),
    .alarm_q (alarm_q),
    .cnt     (cnt_arr),
    .any_en  (any_en),
    .hit_now (hit_now),
    .fire    (fire)
  );

  rtca_flag_ctl u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .ctrl_we     (ctrl_we),
    .wr_flag_bit (host_wdata[FLAG_BIT]),
    .wr_ie_bit   (host_wdata[IE_BIT]),
    .clr_req     (clr_req),
    .flag_q      (alarm_flag),
    .ie_q        (ie_q),
    .irq         (alarm_irq)
  );
endmodule

// File: rtl/rtca_alarm_chk.sv
module rtca_alarm_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic hit_now,
  input logic fire,
  input logic any_en,
  input logic clr_req,
  input logic flag,
  input logic ie,
  input logic irq
);
  // R5: with no enabled field nothing can hit
  a_r5_no_fields_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !any_en |-> !hit_now);

  // R6: a set event only happens on a seconds tick
  a_r6_fire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> tick);

  // R7: the flag only rises after a set event
  a_r7_rise_needs_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(fire));

  // R7: two consecutive set events cannot occur while a hit is held
  a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && hit_now) |=> !fire);

  // R8: a clear without a set empties the flag
  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !fire) |=> !flag);

  // R9: interrupt only while both flag and enable are held
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && ie));

  // R10: a set event wins over a same-cycle clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> flag);
endmodule

bind rtca_alarm_top rtca_alarm_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (sec_tick),
  .hit_now (hit_now),
  .fire    (fire),
  .any_en  (any_en),
  .clr_req (clr_req),
  .flag    (alarm_flag),
  .ie      (ie_q),
  .irq     (alarm_irq)
);

// File: tb/sim_rtca_alarm_top.sv
module sim_rtca_alarm_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  typedef struct packed {
    logic [47:0] alarm;   // sec,min,hour,wday,day,mon from MSB down
    logic [47:0] cnt;
    logic        exp_flag;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    // R4 all six enabled and equal
    '{48'hB0_95_92_83_A1_91, 48'h30_15_12_03_21_11, 1'b1},
    // R4 one enabled field (minute) differs
    '{48'hB0_95_92_83_A1_91, 48'h30_16_12_03_21_11, 1'b0},
    // R3 seconds only, others wildcards
    '{48'hC5_00_00_00_00_00, 48'h45_33_07_02_19_04, 1'b1},
    // R5 nothing enabled
    '{48'h00_00_00_00_00_00, 48'h00_00_00_00_00_00, 1'b0},
    // R2 month only, 1..12 encoding
    '{48'h00_00_00_00_00_92, 48'h01_02_03_04_05_12, 1'b1},
    '{48'h00_00_00_00_00_92, 48'h01_02_03_04_05_11, 1'b0},
    // R4 hour and weekday
    '{48'h00_00_A3_86_00_00, 48'h10_20_23_06_08_09, 1'b1},
    '{48'h00_00_A3_86_00_00, 48'h10_20_23_05_08_09, 1'b0},
    // R3 disabled seconds target differs from counter
    '{48'h12_D9_00_00_00_00, 48'h33_59_00_01_01_01, 1'b1},
    // R2 target in minute slot, value only in seconds counter
    '{48'h00_87_00_00_00_00, 48'h07_08_00_01_01_01, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [3:0] host_idx = '0;
  logic [7:0] host_wdata = '0;
  logic       sec_tick = 1'b0;
  logic [47:0] cnt_bus = '0;
  logic       alarm_flag;
  logic       alarm_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtca_alarm_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_idx   (host_idx),
    .host_wdata (host_wdata),
    .sec_tick   (sec_tick),
    .cnt_sec    (cnt_bus[47:40]),
    .cnt_min    (cnt_bus[39:32]),
    .cnt_hour   (cnt_bus[31:24]),
    .cnt_wday   (cnt_bus[23:16]),
    .cnt_day    (cnt_bus[15:8]),
    .cnt_mon    (cnt_bus[7:0]),
    .alarm_flag (alarm_flag),
    .alarm_irq  (alarm_irq)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    host_we = 1'b0;
    sec_tick = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] data);
    host_we = 1'b1;
    host_idx = idx;
    host_wdata = data;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic tick_with(input logic [47:0] c);
    cnt_bus = c;
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic load_alarm(input logic [47:0] a);
    for (int f = 0; f < 6; f++) wr(4'(8 + f), a[47 - 8*f -: 8]);
  endtask

  localparam logic [47:0] MATCH_A = 48'hC5_00_00_00_00_00;
  localparam logic [47:0] MATCH_C = 48'h45_00_00_00_00_00;
  localparam logic [47:0] MISS_C  = 48'h44_00_00_00_00_00;

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flag after reset", alarm_flag, 1'b0);
    check("R1 irq after reset", alarm_irq, 1'b0);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      load_alarm(VECS[v].alarm);
      tick_with(VECS[v].cnt);
      check($sformatf("R2/R3/R4/R5 vector %0d", v), alarm_flag, VECS[v].exp_flag);
    end

    // R6: counters match but no tick
    do_reset();
    load_alarm(MATCH_A);
    cnt_bus = MATCH_C;
    repeat (4) @(negedge clk);
    check("R6 no tick no flag", alarm_flag, 1'b0);
    tick_with(MATCH_C);
    check("R6 tick sets flag", alarm_flag, 1'b1);

    // R9: enable clear, flag set
    check("R9 irq masked", alarm_irq, 1'b0);
    // R8: write 1 to flag bit keeps it, bit 3 enables
    wr(4'd14, 8'h09);
    check("R8 write one keeps flag", alarm_flag, 1'b1);
    check("R9 irq asserted", alarm_irq, 1'b1);
    wr(4'd14, 8'h08);
    check("R8 write zero clears flag", alarm_flag, 1'b0);
    check("R9 irq drops with flag", alarm_irq, 1'b0);
    wr(4'd14, 8'h09);
    check("R8 write one does not set", alarm_flag, 1'b0);

    // R7: held match does not re-set
    tick_with(MATCH_C);
    tick_with(MATCH_C);
    check("R7 held match no re-set", alarm_flag, 1'b0);
    tick_with(MISS_C);
    tick_with(MATCH_C);
    check("R7 new match sets", alarm_flag, 1'b1);

    // R10: clear and set in the same cycle
    wr(4'd14, 8'h08);
    tick_with(MISS_C);
    check("R10 pre-clear", alarm_flag, 1'b0);
    host_we = 1'b1;
    host_idx = 4'd14;
    host_wdata = 8'h08;
    cnt_bus = MATCH_C;
    sec_tick = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
    sec_tick = 1'b0;
    check("R10 set wins over clear", alarm_flag, 1'b1);

    // R11: writes outside 8..14 ignored
    do_reset();
    wr(4'd7, 8'hFF);
    wr(4'd15, 8'hFF);
    wr(4'd0, 8'hFF);
    tick_with(48'h7F_7F_7F_7F_7F_7F);
    check("R11 stray writes leave alarms disabled", alarm_flag, 1'b0);
    load_alarm(MATCH_A);
    tick_with(MISS_C);
    tick_with(MATCH_C);
    check("R11 flag sets normally", alarm_flag, 1'b1);
    check("R11 stray write left enable clear", alarm_irq, 1'b0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule